// File: doc/BRIEF.md
# Pipelined Burst SRAM Address Front-End

This block is the synchronous control front of a pipelined burst memory. On every rising clock edge it looks at two active-low address strobes: one from a processor, one from a controller. When a strobe is accepted, the external address is stored in an address register, and its two lowest bits are loaded into a 2-bit burst counter. A separate advance input then steps the counter through the burst. The upper address bits stay where they are.

A read cycle returns data one clock after the address is held. That data is driven onto a shared bidirectional bus made of data lines and parity lines. The bus is driven only when output enable is low and the block is not asleep. A controller strobe taken with write enable low starts a write cycle. In a write cycle, the bus word is stored into the array on each later rising edge. The processor strobe wins over the controller strobe, but it counts only while chip enable is low. An asynchronous sleep input freezes all state, keeps the stored contents, and releases the bus.

Top module: `burst_sram_front`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), the bus stays undriven even with oe_n low, until a read cycle has been started.
- R2: A strobe is recognised at a rising edge when proc_stb_n is 0 and cs_n is 0, or when ctrl_stb_n is 0. The edge then stores addr and sets the burst counter to addr[1:0].
- R3: proc_stb_n low is ignored at an edge where cs_n is 1. The held address does not change.
- R4: When both strobes are low and cs_n is 0, only the processor strobe counts. The cycle is a read whatever the value of wr_n.
- R5: A controller strobe taken with wr_n = 0 starts a write cycle. At every later rising edge, up to but not including the next recognised strobe, the word {dqp, dq} is stored at the current address.
- R6: A controller strobe taken with wr_n = 1 starts a read cycle, and it is accepted whatever the value of cs_n.
- R7: In a read cycle, the word at the address held before rising edge k is on the bus after edge k.
- R8: When adv is 1 and no strobe is recognised, the counter steps by one modulo 4 (3 wraps to 0), and the upper address bits do not change.
- R9: At an edge where a strobe is recognised, adv has no effect.
- R10: When oe_n is 1, dq and dqp are high-impedance.
- R11: While sleep is 1, the bus is released at once, strobes, advance and writes are ignored, and the stored words are kept. Normal operation starts again from the first rising edge after sleep falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip enable, active low, gates the processor strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| wr_n | input | 1 | Write select sampled with the controller strobe, 0 = write |
| adv | input | 1 | Burst advance, active high |
| addr | input | ADDR_W | External word address |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dq | inout | DATA_W | Bidirectional data lines |
| dqp | inout | PAR_W | Bidirectional parity lines |

## Verification
The array is first filled by write bursts. Advance is held high during these bursts, so each word position depends on the counter stepping correctly. A table of single-edge cycles then tests these cases:
- the processor strobe with chip enable low and then high, which shows the gating;
- a controller read with chip enable high and advance high, which shows both that the controller strobe is not gated and that advance is ignored on a strobe edge;
- both strobes together with write enable low, where the old word reading back unchanged shows the processor won;
- a burst that wraps from 3 to 0, which shows the upper bits are kept;
- output enable high against low.

Directed tests cover the bus right after reset, a write followed by a read-back, and a sleep period holding a write strobe and write data. That data must leave both the held address and the array contents untouched.

// File: rtl/sram_fe_pkg.sv
// Package: shared cycle type and default sizes for the burst SRAM front-end.
// Assumes: all users take widths from their own parameters; these are defaults.
package sram_fe_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_PAR_W  = 4;

    // Kind of cycle opened by the last recognised strobe.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

endpackage

// File: rtl/sram_strobe_arb.sv
// Module: sram_strobe_arb
// Decides which address strobe, if any, counts in the current cycle.
// The processor strobe needs chip enable low and wins over the controller
// strobe. The controller strobe is not gated by chip enable. Sleep masks both.
// Assumes: all inputs are stable around the rising edge that samples them.
module sram_strobe_arb (
    input  logic cs_n,
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    input  logic wr_n,
    input  logic sleep,
    output logic hit,
    output logic hit_write
);

    logic proc_ok;
    logic ctrl_ok;

    // Qualify each strobe and apply the fixed processor priority.
    always_comb begin
        proc_ok   = !proc_stb_n && !cs_n && !sleep;
        ctrl_ok   = !ctrl_stb_n && !sleep && !proc_ok;
        hit       = proc_ok || ctrl_ok;
        hit_write = ctrl_ok && !wr_n;
    end

endmodule

// File: rtl/sram_addr_ctrl.sv
// Module: sram_addr_ctrl
// Holds the upper address bits, the 2-bit linear burst counter and the kind
// of the current cycle. A recognised strobe reloads all three. Otherwise the
// advance input steps the counter modulo 4.
// Assumes: sleep has already been folded into hit; it is also applied here
// so that advance freezes too.
module sram_addr_ctrl
    import sram_fe_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              hit,
    input  logic              hit_write,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-3:0] addr_hi,
    output logic [1:0]        burst_cnt,
    output cyc_e              cyc
);

    localparam int HI_W = ADDR_W - 2;

    // Upper address register: loaded only on a recognised strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi <= '0;
        end else if (hit) begin
            addr_hi <= addr[ADDR_W-1:2];
        end
    end

    // Burst counter: load on strobe, else step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_cnt <= 2'd0;
        end else if (hit) begin
            burst_cnt <= addr[1:0];
        end else if (adv && !sleep) begin
            burst_cnt <= burst_cnt + 2'd1;
        end
    end

    // Cycle kind: set by each recognised strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= CYC_IDLE;
        end else if (hit) begin
            cyc <= hit_write ? CYC_WRITE : CYC_READ;
        end
    end

    logic [HI_W-1:0] unused_hi_chk;
    assign unused_hi_chk = addr_hi;

endmodule

// File: rtl/sram_array.sv
// Module: sram_array
// Behavioural word store with a registered read port, which gives the
// one-cycle pipeline to the bus. A write is taken from the bus word at a
// rising edge while in a write cycle, except on a strobe edge.
// Assumes: contents are not reset, so only written words are meaningful.
module sram_array
    import sram_fe_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_DATA_W + DEF_PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              hit,
    input  cyc_e              cyc,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              we;

    // Write qualifier: write cycle, awake, not a strobe edge.
    always_comb begin
        we = (cyc == CYC_WRITE) && !sleep && !hit;
    end

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[eff_addr] <= wdata;
        end
    end

    // Pipelined read register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (!sleep) begin
            rdata  <= mem[eff_addr];
            rvalid <= (cyc == CYC_READ);
        end
    end

endmodule

// File: rtl/burst_sram_front.sv
// Module: burst_sram_front (top)
// Control front of a pipelined burst SRAM. It contains the strobe
// arbitration, the address register with burst counter, the word store with
// its pipelined read, and the tri-state drive of the data and parity lines.
// Assumes: the bus master keeps oe_n high whenever it drives write data.
module burst_sram_front
    import sram_fe_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int PAR_W  = DEF_PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              wr_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              sleep,
    inout  wire  [DATA_W-1:0] dq,
    inout  wire  [PAR_W-1:0]  dqp
);

    localparam int WORD_W = DATA_W + PAR_W;

    logic              hit;
    logic              hit_write;
    logic [ADDR_W-3:0] addr_hi;
    logic [1:0]        burst_cnt;
    cyc_e              cyc;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;
    logic              rvalid;
    logic              bus_drv;
    logic              wr_mode;

    sram_strobe_arb u_arb (
        .cs_n       (cs_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .wr_n       (wr_n),
        .sleep      (sleep),
        .hit        (hit),
        .hit_write  (hit_write)
    );

    sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .hit       (hit),
        .hit_write (hit_write),
        .adv       (adv),
        .addr      (addr),
        .addr_hi   (addr_hi),
        .burst_cnt (burst_cnt),
        .cyc       (cyc)
    );

    sram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .hit      (hit),
        .cyc      (cyc),
        .eff_addr (eff_addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    // Effective address, bus drive enable and the incoming bus word.
    always_comb begin
        eff_addr = {addr_hi, burst_cnt};
        wr_mode  = (cyc == CYC_WRITE);
        bus_drv  = rvalid && !oe_n && !sleep;
        wdata    = {dqp, dq};
    end

    // Tri-state drivers, one per data and parity line.
    for (genvar i = 0; i < DATA_W; i++) begin : g_dq
        assign dq[i] = bus_drv ? rdata[i] : 1'bz;
    end
    for (genvar j = 0; j < PAR_W; j++) begin : g_dqp
        assign dqp[j] = bus_drv ? rdata[DATA_W+j] : 1'bz;
    end

endmodule

// File: rtl/burst_sram_front_chk.sv
// Module: burst_sram_front_chk
// Property checker bound to burst_sram_front. It watches the strobes,
// advance, sleep and output enable against the held address, cycle kind and
// bus drive.
// Assumes: rst_n is low at the first clock edge.
module burst_sram_front_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              proc_stb_n,
    input logic              ctrl_stb_n,
    input logic              wr_n,
    input logic              adv,
    input logic [ADDR_W-1:0] addr,
    input logic              oe_n,
    input logic              sleep,
    input logic [ADDR_W-3:0] addr_hi,
    input logic [1:0]        burst_cnt,
    input logic              wr_mode,
    input logic              bus_drv
);

    logic p_ok;
    logic c_only;
    logic any_hit;

    // Strobe qualification seen from the ports.
    always_comb begin
        p_ok    = !proc_stb_n && !cs_n && !sleep;
        c_only  = !ctrl_stb_n && !sleep && !p_ok;
        any_hit = p_ok || c_only;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bus_drv);                                           // R1
    AST_GATED_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && cs_n && ctrl_stb_n && !adv && !sleep)
        |=> ($stable(addr_hi) && $stable(burst_cnt)));                        // R3
    AST_PROC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && !cs_n && !ctrl_stb_n && !sleep) |=> !wr_mode);       // R4
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && !wr_n && !p_ok && !sleep) |=> wr_mode);              // R5
    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && wr_n && !p_ok && !sleep) |=> !wr_mode);              // R6
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && adv && !sleep)
        |=> ((burst_cnt == $past(burst_cnt) + 2'd1) && $stable(addr_hi)));   // R8
    AST_STB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> (burst_cnt == $past(addr[1:0])));                         // R9
    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_drv);                                                   // R10
    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !bus_drv);                                                  // R11
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(addr_hi) && $stable(burst_cnt)));                  // R11

endmodule

bind burst_sram_front burst_sram_front_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .wr_n       (wr_n),
    .adv        (adv),
    .addr       (addr),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .addr_hi    (addr_hi),
    .burst_cnt  (burst_cnt),
    .wr_mode    (wr_mode),
    .bus_drv    (bus_drv)
);

// File: tb/burst_sram_front_bench.sv
// Bench for burst_sram_front: fills the array with write bursts, walks a
// table of single-edge cycles, then runs directed reset, write and sleep tests.
module burst_sram_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int PW = 4;
    localparam int WW = DW + PW;
    localparam int NVEC = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, proc_stb_n, ctrl_stb_n, wr_n, adv, oe_n, sleep;
    logic [AW-1:0] addr;
    logic          tb_drv;
    logic [WW-1:0] tb_word;
    wire  [DW-1:0] dq;
    wire  [PW-1:0] dqp;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side bus driver and pull-ups: an undriven bus reads all ones.
    assign dq  = tb_drv ? tb_word[DW-1:0]  : 'z;
    assign dqp = tb_drv ? tb_word[WW-1:DW] : 'z;
    for (genvar i = 0; i < DW; i++) begin : g_pu_dq
        pullup (dq[i]);
    end
    for (genvar i = 0; i < PW; i++) begin : g_pu_dqp
        pullup (dqp[i]);
    end

    burst_sram_front u_burst_sram_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .proc_stb_n(proc_stb_n),
        .ctrl_stb_n(ctrl_stb_n), .wr_n(wr_n), .adv(adv), .addr(addr),
        .oe_n(oe_n), .sleep(sleep), .dq(dq), .dqp(dqp)
    );

    // Fill pattern; the fixed byte 8'hC3 keeps it from ever being all ones.
    function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
        return {4'(a[3:0]) ^ 4'h5, 8'hC3, 2'b00, a, 16'h1234 + 16'(a)};
    endfunction

    // Table row: inputs for one edge, then what the bus shows after it.
    typedef struct packed {
        logic          pn;
        logic          cn;
        logic          ce;
        logic          wn;
        logic          av;
        logic          oe;
        logic [AW-1:0] a;
        logic          ez;
        logic [AW-1:0] ea;
        logic [3:0]    rq;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,6'h13, 1'b1,6'h00, 4'd2},  // R2 strobe after writes: bus idle
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h13, 4'd7},  // R7 data one edge later
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,6'h00, 1'b0,6'h13, 4'd8},  // R8 advance 3 -> 0
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h10, 4'd8},  // R8 wrap kept upper bits
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,6'h00, 1'b0,6'h10, 4'd8},  // R8 advance 0 -> 1
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,6'h2A, 1'b0,6'h11, 4'd3},  // R3 gated processor strobe
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h11, 4'd3},  // R3 address unchanged
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,6'h25, 1'b0,6'h11, 4'd6},  // R6 controller read, cs_n high
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h25, 4'd9},  // R9 adv ignored on strobe
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h3C, 1'b0,6'h25, 4'd4},  // R4 both strobes, wr_n low
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h3C, 4'd4},  // R4 read, word unchanged
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,6'h00, 1'b1,6'h00, 4'd10}, // R10 oe_n high
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h00, 1'b0,6'h3C, 4'd10}  // R10 oe_n low again
    };

    task automatic idle_inputs();
        cs_n = 1'b0; proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; wr_n = 1'b1;
        adv = 1'b0; addr = '0; tb_drv = 1'b0; tb_word = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bus(input logic ez, input logic [WW-1:0] exp, input int rq);
        logic [WW-1:0] act;
        logic [WW-1:0] want;
        act  = {dqp, dq};
        want = ez ? '1 : exp;
        n_tests++;
        if (act !== want) begin
            n_fail++;
            $display("FAIL R%0d: bus actual %h expected %h", rq, act, want);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        @(negedge clk);
        step();
        rst_n = 1'b1;
        step();
        check_bus(1'b1, '0, 1);                      // R1 undriven after reset

        // Fill with write bursts, advancing each edge (R5, R8).
        oe_n = 1'b1;
        for (int b = 0; b < (1 << AW) / 4; b++) begin
            idle_inputs();
            ctrl_stb_n = 1'b0; wr_n = 1'b0; addr = AW'(b * 4);
            step();
            idle_inputs();
            adv = 1'b1; tb_drv = 1'b1;
            for (int k = 0; k < 4; k++) begin
                tb_word = pat(AW'(b * 4 + k));
                step();
            end
        end

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            idle_inputs();
            proc_stb_n = VEC[v].pn; ctrl_stb_n = VEC[v].cn; cs_n = VEC[v].ce;
            wr_n = VEC[v].wn; adv = VEC[v].av; oe_n = VEC[v].oe; addr = VEC[v].a;
            step();
            check_bus(VEC[v].ez, pat(VEC[v].ea), int'(VEC[v].rq));
        end

        // R5: single write of a fresh word, then read it back.
        idle_inputs(); oe_n = 1'b1;
        ctrl_stb_n = 1'b0; wr_n = 1'b0; addr = 6'h05;
        step();
        idle_inputs(); tb_drv = 1'b1; tb_word = 36'h9_8765_4321;
        step();
        idle_inputs(); proc_stb_n = 1'b0; addr = 6'h05;
        step();
        idle_inputs(); oe_n = 1'b0;
        step();
        check_bus(1'b0, 36'h9_8765_4321, 5);         // R5 written word reads back
        idle_inputs(); proc_stb_n = 1'b0; addr = 6'h06;
        step();
        idle_inputs();
        step();
        check_bus(1'b0, pat(6'h06), 5);              // R5 neighbour untouched

        // R11: sleep releases the bus at once and freezes everything.
        sleep = 1'b1;
        #1;
        check_bus(1'b1, '0, 11);                     // R11 bus released immediately
        oe_n = 1'b1; ctrl_stb_n = 1'b0; wr_n = 1'b0; addr = 6'h00;
        step();
        idle_inputs(); adv = 1'b1; tb_drv = 1'b1; tb_word = '0;
        step();
        step();
        idle_inputs(); oe_n = 1'b0;
        #1;
        check_bus(1'b1, '0, 11);                     // R11 still released with oe_n low
        sleep = 1'b0;
        step();
        check_bus(1'b0, pat(6'h06), 11);             // R11 address held, resumes at first edge
        proc_stb_n = 1'b0; addr = 6'h00;
        step();
        idle_inputs();
        step();
        check_bus(1'b0, pat(6'h00), 11);             // R11 write while asleep was ignored

        // R1 again: reset mid-run returns the bus to undriven.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check_bus(1'b1, '0, 1);                      // R1 undriven after second reset

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule